// File: doc/BRIEF.md
# Gated Frequency Counter with Integration

This block measures the frequency of an intermediate-frequency signal by counting its rising edges over a gate window. The window is timed by a slow time-base tick input, and its length is chosen from four settings. Before edges reach the counter, the measured signal passes through a synchronizer and a divide-by-two stage, so the count equals half the number of input edges. A counter-path select bit must be high for any edge to count. A start command opens a measurement. In normal mode the start clears the previous result. In integrate mode it keeps the result and the prescaler phase, so successive gates add to one running total.

The control is a four-state machine:
- **IDLE**: nothing runs.
- **ALIGN**: the gate is armed and waits for the next tick.
- **GATE**: edges are counted while ticks are counted down.
- **DONE**: a one-cycle state on close, returning to IDLE.

Transitions:
- *accept* (start seen in IDLE or DONE) goes to ALIGN.
- *open* (tick in ALIGN) goes to GATE.
- *close* (final tick in GATE) goes to DONE.
- *retire* (DONE with no start) goes to IDLE.

The result is visible in parallel on the count port. It can also be read serially, most significant bit first: a load pulse snapshots the count into a shifter, and each step pulse advances it by one bit.

Top module: `fc_gated_counter`

## Requirements
- R1: After reset, count is 0, busy is 0, done is 0 and sdo is 0.
- R2: In a fresh measurement, K rising edges of meas_in inside the gate give a count of ceil(K/2). The first edge after a clearing start is counted, then every second edge.
- R3: A start accepted with integ=0 clears the count to 0 and resets the divide-by-two phase, at the same clock edge that raises busy.
- R4: A start accepted with integ=1 keeps both the count and the divide-by-two phase, so counting continues from the previous total.
- R5: gate_sel is sampled at start, with the encoding 0 = 1 tick, 1 = 4 ticks, 2 = 8 ticks, 3 = 32 ticks. The gate opens on the first tick after start and closes on the selected number of further ticks. busy is high from the cycle after start until the gate closes.
- R6: done rises at the clock edge where the gate closes. It stays high until the next accepted start, which clears it at the same edge.
- R7: While path_en is 0, edges in the gate neither change the count nor advance the divide-by-two phase.
- R8: The count saturates at 2^CNT_W-1 instead of wrapping, including across integrated gates.
- R9: Edges arriving while no gate is open (idle) affect neither the count nor the divide-by-two phase.
- R10: A start while busy is ignored: the count is not cleared and the gate keeps its original length.
- R11: rd_load copies the count into the shifter, and sdo shows its MSB from the next cycle. Each rd_step moves the next lower bit to sdo. When both pulse in the same cycle, the load wins.
- R12: An edge whose counting pulse falls in the same cycle as the closing tick is included in the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| meas_in | input | 1 | Measured signal, asynchronous to clk |
| path_en | input | 1 | Counter path select; edges count only when 1 |
| start | input | 1 | Start a measurement (one-cycle pulse) |
| gate_sel | input | 2 | Gate length select, sampled at start |
| integ | input | 1 | Integrate mode, sampled at start |
| tick | input | 1 | Time-base tick pulse |
| rd_load | input | 1 | Snapshot the count into the serial shifter |
| rd_step | input | 1 | Shift the serial shifter by one bit |
| count | output | CNT_W | Current measurement result |
| busy | output | 1 | Gate armed or open |
| done | output | 1 | Measurement finished |
| sdo | output | 1 | Serial result bit, MSB first |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the close of the gate and the counting of an edge. The bench raises meas_in at a falling clock edge and asserts the final tick exactly two rising edges later. This places the synchronized counting pulse in the cycle that closes the gate, and the scoreboard expects that edge in the result.

The second pair is the serial snapshot and the shift. The bench pulses rd_load and rd_step together and then expects the MSB on sdo, followed by the next bit after a single further step.

// File: rtl/fc_pkg.sv
package fc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_GATE  = 2'd2,
        ST_DONE  = 2'd3
    } fc_state_e;

    typedef enum logic [1:0] {
        GSEL_SHORT  = 2'd0,
        GSEL_MID    = 2'd1,
        GSEL_LONG   = 2'd2,
        GSEL_XLONG  = 2'd3
    } fc_gsel_e;

endpackage

// File: rtl/fc_prescale.sv
// Synchronizes the measured signal, detects rising edges and divides them by two.
module fc_prescale #(
    parameter int unsigned SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    input  logic clr,
    input  logic run,
    output logic pulse
);
    localparam int unsigned TOP = SYNC_N - 1;

    logic [TOP:0] chain;
    logic         prev;
    logic         phase;
    logic         rise;

    generate
        if (SYNC_N == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= sig_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[TOP-1:0], sig_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[TOP];
    end

    assign rise = chain[TOP] & ~prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            phase <= 1'b0;
        else if (clr)          phase <= 1'b0;
        else if (run && rise)  phase <= ~phase;
    end

    assign pulse = run & rise & ~phase;

endmodule

// File: rtl/fc_gate_timer.sv
// Counts down time-base ticks for the selected gate length.
module fc_gate_timer #(
    parameter int unsigned LEN0 = 1,
    parameter int unsigned LEN1 = 4,
    parameter int unsigned LEN2 = 8,
    parameter int unsigned LEN3 = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] sel,
    input  logic       en,
    input  logic       tick,
    output logic       expire
);
    localparam int unsigned M01  = (LEN0 > LEN1) ? LEN0 : LEN1;
    localparam int unsigned M23  = (LEN2 > LEN3) ? LEN2 : LEN3;
    localparam int unsigned LMAX = (M01 > M23) ? M01 : M23;
    localparam int unsigned TW   = $clog2(LMAX + 1);

    logic [TW-1:0] remain;
    logic [TW-1:0] len_sel;

    always_comb begin
        unique case (sel)
            2'd0:    len_sel = TW'(LEN0);
            2'd1:    len_sel = TW'(LEN1);
            2'd2:    len_sel = TW'(LEN2);
            default: len_sel = TW'(LEN3);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             remain <= '0;
        else if (load)                          remain <= len_sel;
        else if (en && tick && remain != '0)    remain <= remain - 1'b1;
    end

    assign expire = en & tick & (remain == TW'(1));

endmodule

// File: rtl/fc_sat_counter.sv
// Saturating up-counter with synchronous clear.
module fc_sat_counter #(
    parameter int unsigned W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] MAXV = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     value <= '0;
        else if (clr)                   value <= '0;
        else if (inc && value != MAXV)  value <= value + 1'b1;
    end

endmodule

// File: rtl/fc_serial_out.sv
// Snapshot shifter presenting the result MSB first.
module fc_serial_out #(
    parameter int unsigned W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] data,
    output logic         sdo
);
    logic [W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     shreg <= '0;
        else if (load)  shreg <= data;
        else if (step)  shreg <= {shreg[W-2:0], 1'b0};
    end

    assign sdo = shreg[W-1];

endmodule

// File: rtl/fc_gated_counter.sv
module fc_gated_counter
    import fc_pkg::*;
#(
    parameter int unsigned CNT_W   = 20,
    parameter int unsigned SYNC_N  = 2,
    parameter int unsigned GATE_T0 = 1,
    parameter int unsigned GATE_T1 = 4,
    parameter int unsigned GATE_T2 = 8,
    parameter int unsigned GATE_T3 = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_in,
    input  logic             path_en,
    input  logic             start,
    input  logic [1:0]       gate_sel,
    input  logic             integ,
    input  logic             tick,
    input  logic             rd_load,
    input  logic             rd_step,
    output logic [CNT_W-1:0] count,
    output logic             busy,
    output logic             done,
    output logic             sdo
);
    fc_state_e  state_q, state_d;
    logic [1:0] sel_q;
    logic       done_q;

    logic accept;
    logic fresh;
    logic tmr_load;
    logic gate_open;
    logic run;
    logic edge_pulse;
    logic expire;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: accept, open, close, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_ALIGN;
            ST_ALIGN: if (tick)  state_d = ST_GATE;
            ST_GATE:  if (expire) state_d = ST_DONE;
            ST_DONE:  state_d = start ? ST_ALIGN : ST_IDLE;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        accept    = 1'b0;
        tmr_load  = 1'b0;
        gate_open = 1'b0;
        busy      = 1'b0;
        unique case (state_q)
            ST_IDLE:  accept = start;
            ST_ALIGN: begin
                busy     = 1'b1;
                tmr_load = tick;
            end
            ST_GATE:  begin
                busy      = 1'b1;
                gate_open = 1'b1;
            end
            ST_DONE:  accept = start;
        endcase
        fresh = accept & ~integ;
        run   = gate_open & path_en;
    end

    // Parameters of a measurement are captured when it is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_q <= 2'd0;
        else if (accept) sel_q <= gate_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  done_q <= 1'b0;
        else if (accept)             done_q <= 1'b0;
        else if (gate_open && expire) done_q <= 1'b1;
    end

    assign done = done_q;

    fc_prescale #(
        .SYNC_N (SYNC_N)
    ) u_prescale (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (meas_in),
        .clr    (fresh),
        .run    (run),
        .pulse  (edge_pulse)
    );

    fc_gate_timer #(
        .LEN0 (GATE_T0),
        .LEN1 (GATE_T1),
        .LEN2 (GATE_T2),
        .LEN3 (GATE_T3)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .sel    (sel_q),
        .en     (gate_open),
        .tick   (tick),
        .expire (expire)
    );

    fc_sat_counter #(
        .W (CNT_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fresh),
        .inc   (edge_pulse),
        .value (count)
    );

    fc_serial_out #(
        .W (CNT_W)
    ) u_serial (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (rd_load),
        .step  (rd_step),
        .data  (count),
        .sdo   (sdo)
    );

endmodule

// File: rtl/fc_gated_counter_chk.sv
module fc_gated_counter_chk #(
    parameter int unsigned CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             path_en,
    input logic             start,
    input logic             rd_load,
    input logic             rd_step,
    input logic [CNT_W-1:0] count,
    input logic             busy,
    input logic             done,
    input logic             sdo
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_done_after_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    assert_busy_from_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && count == MAXV) |=> count == MAXV);

    assert_no_clear_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> count >= $past(count));

    assert_path_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !path_en) |=> $stable(count));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(count));

    assert_load_msb_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |=> sdo == $past(count[CNT_W-1]));

    assert_shift_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_load && !rd_step) |=> $stable(sdo));

endmodule

bind fc_gated_counter fc_gated_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .path_en (path_en),
    .start   (start),
    .rd_load (rd_load),
    .rd_step (rd_step),
    .count   (count),
    .busy    (busy),
    .done    (done),
    .sdo     (sdo)
);

// File: tb/test_fc_gated_counter.sv
module test_fc_gated_counter;
    localparam int W    = 8;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         meas_in = 1'b0;
    logic         path_en = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   gate_sel = 2'd0;
    logic         integ = 1'b0;
    logic         tick = 1'b0;
    logic         rd_load = 1'b0;
    logic         rd_step = 1'b0;
    logic [W-1:0] count;
    logic         busy;
    logic         done;
    logic         sdo;

    fc_gated_counter #(.CNT_W(W)) i_fc_gated_counter (
        .clk(clk), .rst_n(rst_n), .meas_in(meas_in), .path_en(path_en),
        .start(start), .gate_sel(gate_sel), .integ(integ), .tick(tick),
        .rd_load(rd_load), .rd_step(rd_step), .count(count), .busy(busy),
        .done(done), .sdo(sdo)
    );

    always #5 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_cnt = 0;
    bit ph = 1'b0;
    int exp_q[$];
    logic done_prev = 1'b0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int glen(input int sel);
        case (sel)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 32;
        endcase
    endfunction

    // Monitor: pops an expected result on every rise of done
    always @(negedge clk) begin
        if (rst_n && done && !done_prev) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 done without pending measurement", 1, 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(count == W'(e), "R2 scoreboard result", int'(count), e);
            end
        end
        done_prev = done;
    end

    task automatic pulse_tick;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic edges(input int k, input bit counted);
        for (int i = 0; i < k; i++) begin
            meas_in = 1'b1;
            repeat (3) @(negedge clk);
            meas_in = 1'b0;
            repeat (3) @(negedge clk);
            if (counted) begin
                if (!ph && exp_cnt < MAXV) exp_cnt++;
                ph = ~ph;
            end
        end
    endtask

    task automatic run_gate(input int sel, input bit ig, input bit en, input int k,
                            input bit poke, input string req);
        @(negedge clk);
        gate_sel = 2'(sel);
        integ    = ig;
        path_en  = en;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!ig) begin
            exp_cnt = 0;
            ph = 1'b0;
        end
        check(busy == 1'b1, {req, " R5 busy after start"}, int'(busy), 1);
        check(done == 1'b0, {req, " R6 done cleared by start"}, int'(done), 0);
        if (!ig) check(count == 0, {req, " R3 count cleared"}, int'(count), 0);
        else     check(count == W'(exp_cnt), {req, " R4 count kept"}, int'(count), exp_cnt);
        @(negedge clk);
        pulse_tick();
        repeat (3) @(negedge clk);
        edges(k, en);
        if (poke) begin
            gate_sel = 2'd0;
            integ    = 1'b0;
            start    = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(busy == 1'b1, "R10 start while busy keeps gate", int'(busy), 1);
            check(count == W'(exp_cnt), "R10 start while busy keeps count", int'(count), exp_cnt);
        end
        repeat (6) @(negedge clk);
        for (int i = 0; i < glen(sel); i++) begin
            if (i == glen(sel) - 1) begin
                check(busy == 1'b1, {req, " R5 gate open before last tick"}, int'(busy), 1);
                exp_q.push_back(exp_cnt);
            end
            pulse_tick();
            repeat (2) @(negedge clk);
        end
        check(done == 1'b1 && busy == 1'b0, {req, " R6 done after last tick"},
              int'({busy, done}), 1);
    endtask

    task automatic read_serial(input string req);
        logic [W-1:0] ev;
        ev = W'(exp_cnt);
        @(negedge clk);
        rd_load = 1'b1;
        @(negedge clk);
        rd_load = 1'b0;
        for (int i = 0; i < W; i++) begin
            check(sdo == ev[W-1-i], {req, " R11 serial bit"}, int'(sdo), int'(ev[W-1-i]));
            rd_step = 1'b1;
            @(negedge clk);
            rd_step = 1'b0;
        end
        check(done == 1'b1, {req, " R6 done held while idle"}, int'(done), 1);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(count == 0, "R1 reset count", int'(count), 0);
        check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        check(done == 1'b0, "R1 reset done", int'(done), 0);
        check(sdo == 1'b0, "R1 reset sdo", int'(sdo), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: fresh gate, 4 ticks, 7 edges -> 4
        run_gate(1, 1'b0, 1'b1, 7, 1'b0, "R2");
        read_serial("R2");

        // R4: integrate, phase carried
        run_gate(0, 1'b1, 1'b1, 5, 1'b0, "R4");

        // R9: odd number of idle edges must not touch count or phase
        path_en = 1'b1;
        edges(5, 1'b0);
        check(count == W'(exp_cnt), "R9 idle edges ignored", int'(count), exp_cnt);
        run_gate(0, 1'b1, 1'b1, 3, 1'b0, "R9");

        // R7: path disabled over a 32-tick gate
        run_gate(3, 1'b1, 1'b0, 6, 1'b0, "R7");

        // R3: fresh start clears, 8 ticks
        run_gate(2, 1'b0, 1'b1, 10, 1'b0, "R3");

        // R10: start while busy ignored
        run_gate(1, 1'b0, 1'b1, 3, 1'b1, "R10");

        // R12: counting pulse in the closing-tick cycle
        @(negedge clk);
        gate_sel = 2'd0; integ = 1'b0; path_en = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        exp_cnt = 0; ph = 1'b0;
        @(negedge clk);
        pulse_tick();
        repeat (3) @(negedge clk);
        meas_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        tick = 1'b1;
        exp_cnt = 1; ph = 1'b1;
        exp_q.push_back(exp_cnt);
        @(negedge clk);
        tick = 1'b0;
        meas_in = 1'b0;
        repeat (2) @(negedge clk);
        check(done == 1'b1, "R12 gate closed", int'(done), 1);
        check(count == 1, "R12 edge at closing tick counted", int'(count), 1);

        // R8: saturation, then integration stays saturated
        run_gate(0, 1'b0, 1'b1, 520, 1'b0, "R8");
        check(count == W'(MAXV), "R8 saturated", int'(count), MAXV);
        run_gate(0, 1'b1, 1'b1, 4, 1'b0, "R8");
        check(count == W'(MAXV), "R8 saturated after integrate", int'(count), MAXV);

        // R11: new fresh value, then load and step in the same cycle
        run_gate(1, 1'b0, 1'b1, 11, 1'b0, "R11");
        read_serial("R11");
        begin
            logic [W-1:0] ev;
            ev = W'(exp_cnt);
            @(negedge clk);
            rd_load = 1'b1;
            rd_step = 1'b1;
            @(negedge clk);
            rd_load = 1'b0;
            rd_step = 1'b0;
            check(sdo == ev[W-1], "R11 load wins over step", int'(sdo), int'(ev[W-1]));
            rd_step = 1'b1;
            @(negedge clk);
            rd_step = 1'b0;
            check(sdo == ev[W-2], "R11 second bit after step", int'(sdo), int'(ev[W-2]));
        end

        check(exp_q.size() == 0, "R6 every measurement reported done",
              exp_q.size(), 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule